// File: doc/BRIEF.md
# Ultra DMA Read-Burst Host Terminator

This block is the host-side end of a read burst in an Ultra DMA style parallel transfer. While a burst is open, every transition of the device strobe (rising or falling) delivers one 16-bit word. The block passes each word downstream as a one-cycle beat, counts the words, and folds each one into a running CRC. The strobe and the device request arrive from another clock domain, so both pass through a two-flop synchronizer before use.

When local logic asks to end the burst, the block first withdraws its ready signal. It still accepts the words that are already in flight. After a fixed minimum delay it raises STOP. From then on it ignores any strobe transition, because such an edge carries no data. It waits for the device to drop its request and lets a turnaround delay pass. It then drives the bus for one cycle with the CRC word, pulses done and presents the final word count. The two timing limits are clock-cycle parameters.

The outgoing word stream is valid-only. `word_valid` is high for one cycle per captured word, and no ready comes back from the sink: the sink must accept every beat. Back-pressure towards the device is applied only through `host_rdy`, and only as part of termination.

Top module: `udma_rd_terminator`

## Requirements
- R1: A termination request (`term_req` high for at least one cycle while the burst is open) is held pending. It is acted on only once at least one word of the current burst has been captured, and `host_rdy` falls in the cycle after that condition is met.
- R2: `host_rdy` rises when the synchronized device request is first seen high. It stays high until termination starts. Once withdrawn, it stays low until the burst has ended.
- R3: Every strobe transition, rising or falling, that is detected before STOP is raised is captured as exactly one word. This includes the words (at least two) that arrive after `host_rdy` has fallen.
- R4: `stop_o` rises exactly `T_RP` clock cycles after `host_rdy` falls. It stays high through the cycle in which the CRC is driven and is low in the following cycle.
- R5: A strobe transition detected while `stop_o` is high is not captured. It produces no beat, does not change the count and does not affect the CRC.
- R6: `bus_drive_en` first rises `T_ZAH + 3` clock edges after the first edge at which `dev_req` is low: two synchronizer stages, one decision cycle and `T_ZAH` turnaround cycles. The bus is never driven while the synchronized request is high.
- R7: The driven word `bus_out` is a CRC-16 with polynomial 0x1021. It is processed MSB-first, with bit 15 of each word first. It is seeded with 0x4ABA at burst start and updated once for each captured word.
- R8: `done_o` is a one-cycle pulse in the cycle the CRC is driven, and `burst_words` then equals the number of captured words. The count is cleared to 0 at burst start.
- R9: While reset is held, `host_rdy`, `stop_o`, `word_valid`, `bus_drive_en` and `done_o` are all low.
- R10: `word_valid` is high for one cycle per captured word, one cycle after the strobe transition is detected. `word_data` then holds the value `dev_data` had at detection. Beats appear in arrival order and are never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_strobe | input | 1 | Device data strobe; each transition marks a word |
| dev_req | input | 1 | Device DMA request, high while the burst is open |
| dev_data | input | DW (16) | Data bus from the device |
| term_req | input | 1 | Local request to end the burst |
| host_rdy | output | 1 | Host ready towards the device |
| stop_o | output | 1 | STOP towards the device |
| word_valid | output | 1 | One-cycle beat strobe for a captured word |
| word_data | output | DW (16) | Captured word |
| burst_words | output | CW (16) | Words captured in the current burst |
| bus_drive_en | output | 1 | Host drives the data bus this cycle |
| bus_out | output | DW (16) | Word driven by the host (the CRC) |
| done_o | output | 1 | Termination complete pulse |

## Verification
The bench builds the block with `T_RP` = 12 and `T_ZAH` = 3. A 12-cycle STOP delay leaves room for two extra words, each needing about four cycles, to cross the synchronizer and land before STOP. This brings the extra-word path of R3 within reach. With those values the bench sweeps bursts of one to five words, each combined with zero, one or two trailing words. It adds a set where the request to stop comes before any word. Every burst ends with a non-data strobe edge after STOP, and the STOP and bus-drive delays are measured in exact cycles.

// File: rtl/udt_pkg.sv
package udt_pkg;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'h4ABA;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_WDRAW,
    ST_STOP,
    ST_TURN,
    ST_DRIVE
  } seq_state_e;
endpackage

// File: rtl/udt_sync.sv
module udt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/udt_crc.sv
module udt_crc #(
  parameter int DW = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       seed,
  input  logic                       upd,
  input  logic [DW-1:0]              din,
  output logic [udt_pkg::CRC_W-1:0]  crc
);
  import udt_pkg::*;

  logic [CRC_W-1:0] nxt;

  always_comb begin
    nxt = crc;
    for (int i = DW - 1; i >= 0; i--) begin
      if (nxt[CRC_W-1] ^ din[i]) nxt = {nxt[CRC_W-2:0], 1'b0} ^ CRC_POLY;
      else                       nxt = {nxt[CRC_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc <= CRC_SEED;
    else if (seed) crc <= CRC_SEED;
    else if (upd)  crc <= nxt;
  end
endmodule

// File: rtl/udt_capture.sv
module udt_capture #(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strb_s,
  input  logic [DW-1:0] data_in,
  input  logic          enable,
  input  logic          clear,
  output logic          cap,
  output logic          word_valid,
  output logic [DW-1:0] word_data,
  output logic [CW-1:0] count
);
  logic strb_d;
  logic strb_edge;

  assign strb_edge = strb_s ^ strb_d;
  assign cap       = strb_edge & enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_d     <= 1'b0;
      word_valid <= 1'b0;
      word_data  <= '0;
      count      <= '0;
    end else begin
      strb_d     <= strb_s;
      word_valid <= cap;
      if (cap) word_data <= data_in;
      if (clear)                          count <= '0;
      else if (cap && count != {CW{1'b1}}) count <= count + 1'b1;
    end
  end

  // R10: a beat never lasts two cycles without a second detected edge
  a_r10_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && $past(word_valid) |-> $past(strb_s) != $past(strb_s, 2));
endmodule

// File: rtl/udt_seq.sv
module udt_seq #(
  parameter int T_RP  = 8,
  parameter int T_ZAH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  input  logic term_req,
  input  logic have_word,
  output logic host_rdy,
  output logic stop_o,
  output logic accept,
  output logic burst_start,
  output logic drive_en,
  output logic done
);
  import udt_pkg::*;

  localparam int TMAX = (T_RP > T_ZAH) ? T_RP : T_ZAH;
  localparam int WCW  = $clog2(TMAX + 1);
  localparam logic [WCW-1:0] RP_LAST  = WCW'(T_RP - 1);
  localparam logic [WCW-1:0] ZAH_LAST = WCW'(T_ZAH - 1);

  seq_state_e state, state_n;
  logic [WCW-1:0] wcnt, wcnt_n;
  logic pend, pend_n;

  always_comb begin
    state_n = state;
    wcnt_n  = wcnt;
    pend_n  = pend;
    unique case (state)
      ST_IDLE: begin
        pend_n = 1'b0;
        if (req_s) state_n = ST_XFER;
      end
      ST_XFER: begin
        if (!req_s) begin
          state_n = ST_IDLE;
        end else if ((term_req || pend) && have_word) begin
          state_n = ST_WDRAW;
          wcnt_n  = '0;
          pend_n  = 1'b0;
        end else if (term_req) begin
          pend_n = 1'b1;
        end
      end
      ST_WDRAW: begin
        wcnt_n = wcnt + 1'b1;
        if (wcnt == RP_LAST) state_n = ST_STOP;
      end
      ST_STOP: begin
        if (!req_s) begin
          state_n = ST_TURN;
          wcnt_n  = '0;
        end
      end
      ST_TURN: begin
        wcnt_n = wcnt + 1'b1;
        if (wcnt == ZAH_LAST) state_n = ST_DRIVE;
      end
      ST_DRIVE: state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      wcnt  <= '0;
      pend  <= 1'b0;
    end else begin
      state <= state_n;
      wcnt  <= wcnt_n;
      pend  <= pend_n;
    end
  end

  assign host_rdy    = (state == ST_XFER);
  assign accept      = (state == ST_XFER) || (state == ST_WDRAW);
  assign stop_o      = (state == ST_STOP) || (state == ST_TURN) || (state == ST_DRIVE);
  assign burst_start = (state == ST_IDLE) && req_s;
  assign drive_en    = (state == ST_DRIVE);
  assign done        = (state == ST_DRIVE);

  // R2: ready never returns while STOP is held
  a_r2_rdy_low_under_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_o) |-> !host_rdy);

  // R4: STOP only drops after the CRC drive cycle
  a_r4_stop_until_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_o) |-> $past(drive_en));
endmodule

// File: rtl/udma_rd_terminator.sv
module udma_rd_terminator #(
  parameter int DW          = 16,
  parameter int CW          = 16,
  parameter int T_RP        = 8,
  parameter int T_ZAH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dev_strobe,
  input  logic          dev_req,
  input  logic [DW-1:0] dev_data,
  input  logic          term_req,
  output logic          host_rdy,
  output logic          stop_o,
  output logic          word_valid,
  output logic [DW-1:0] word_data,
  output logic [CW-1:0] burst_words,
  output logic          bus_drive_en,
  output logic [DW-1:0] bus_out,
  output logic          done_o
);
  import udt_pkg::*;

  logic [1:0] sync_q;
  logic req_s, strb_s;
  logic accept, burst_start, cap;
  logic [CRC_W-1:0] crc;

  udt_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d({dev_req, dev_strobe}), .q(sync_q)
  );
  assign req_s  = sync_q[1];
  assign strb_s = sync_q[0];

  udt_seq #(.T_RP(T_RP), .T_ZAH(T_ZAH)) seq_i (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .term_req(term_req),
    .have_word(burst_words != '0), .host_rdy(host_rdy), .stop_o(stop_o),
    .accept(accept), .burst_start(burst_start), .drive_en(bus_drive_en),
    .done(done_o)
  );

  udt_capture #(.DW(DW), .CW(CW)) cap_i (
    .clk(clk), .rst_n(rst_n), .strb_s(strb_s), .data_in(dev_data),
    .enable(accept), .clear(burst_start), .cap(cap),
    .word_valid(word_valid), .word_data(word_data), .count(burst_words)
  );

  udt_crc #(.DW(DW)) crc_i (
    .clk(clk), .rst_n(rst_n), .seed(burst_start), .upd(cap),
    .din(dev_data), .crc(crc)
  );

  assign bus_out = bus_drive_en ? DW'(crc) : '0;

  // R1: ready is only withdrawn mid-burst once a word has been counted
  a_r1_term_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_rdy) && req_s |-> burst_words != '0);

  // R5: no beat leaves once STOP has been up for a full cycle
  a_r5_stop_blocks_words: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o && $past(stop_o) |-> !word_valid);

  // R6: the bus is driven only after the request is seen low
  a_r6_drive_after_req_low: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_en |-> !req_s && $past(!req_s));

  // R8: done coincides with the CRC drive cycle
  a_r8_done_with_drive: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> bus_drive_en && stop_o);
endmodule

// File: tb/udma_rd_terminator_tb_top.sv
module udma_rd_terminator_tb_top;
  localparam int CLK_NS = 10;
  localparam int DW     = 16;
  localparam int CW     = 16;
  localparam int T_RP   = 12;
  localparam int T_ZAH  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dev_strobe = 1'b0, dev_req = 1'b0, term_req = 1'b0;
  logic [DW-1:0] dev_data = '0;
  logic host_rdy, stop_o, word_valid, bus_drive_en, done_o;
  logic [DW-1:0] word_data, bus_out;
  logic [CW-1:0] burst_words;

  int checks = 0, fails = 0;
  logic [15:0] exp_q [512];
  int exp_n = 0, mon_idx = 0;
  int since = 0;
  logic prev_rdy = 1'b0, prev_stop = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  udma_rd_terminator #(.DW(DW), .CW(CW), .T_RP(T_RP), .T_ZAH(T_ZAH)) dut_i (
    .clk(clk), .rst_n(rst_n), .dev_strobe(dev_strobe), .dev_req(dev_req),
    .dev_data(dev_data), .term_req(term_req), .host_rdy(host_rdy),
    .stop_o(stop_o), .word_valid(word_valid), .word_data(word_data),
    .burst_words(burst_words), .bus_drive_en(bus_drive_en),
    .bus_out(bus_out), .done_o(done_o)
  );

  function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] r = c;
    for (int k = 0; k < 16; k++) begin
      logic msb = r[15] ^ w[15-k];
      r = r << 1;
      if (msb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic send_edge(input logic [15:0] w, input bit is_data);
    @(negedge clk);
    dev_data   = w;
    dev_strobe = ~dev_strobe;
    if (is_data) begin
      exp_q[exp_n] = w;
      exp_n++;
    end
    repeat (3) @(negedge clk);
  endtask

  // R3 / R10: every beat matches the next expected word in order
  always @(negedge clk) begin
    if (rst_n && word_valid) begin
      chk(mon_idx < exp_n && word_data === exp_q[mon_idx], "R10",
          "beat data/order", longint'(word_data),
          longint'(mon_idx < exp_n ? exp_q[mon_idx] : 16'h0));
      mon_idx++;
    end
  end

  // R4: STOP rises exactly T_RP cycles after ready falls
  always @(negedge clk) begin
    if (prev_rdy && !host_rdy) since = 0;
    else since++;
    if (rst_n && !prev_stop && stop_o)
      chk(since == T_RP, "R4", "cycles ready-fall to STOP", since, T_RP);
    prev_rdy  = host_rdy;
    prev_stop = stop_o;
  end

  task automatic run_burst(input int b, input int nw, input int ex, input bit early);
    logic [15:0] crc = 16'h4ABA;
    logic [15:0] w;
    int n;
    @(negedge clk) dev_req = 1'b1;
    n = 0;
    while (!host_rdy && n < 20) begin @(negedge clk); n++; end
    chk(host_rdy, "R2", "ready at burst start", host_rdy, 1);
    chk(burst_words == 0, "R8", "count cleared at start", burst_words, 0);
    if (early) begin
      @(negedge clk) term_req = 1'b1;
      @(negedge clk) term_req = 1'b0;
      repeat (6) @(negedge clk);
      chk(host_rdy, "R1", "ready held with no word yet", host_rdy, 1);
    end
    for (int i = 0; i < nw; i++) begin
      w = 16'((b * 16'h03C5) ^ (i * 16'h1111) ^ 16'hA5A5);
      crc = crc_ref(crc, w);
      send_edge(w, 1'b1);
    end
    if (!early) begin
      @(negedge clk) term_req = 1'b1;
      @(negedge clk) term_req = 1'b0;
    end
    n = 0;
    while (host_rdy && n < 20) begin @(negedge clk); n++; end
    chk(!host_rdy, "R1", "ready withdrawn after request", host_rdy, 0);
    chk(burst_words == CW'(nw), "R1", "words before withdrawal", burst_words, nw);
    for (int i = 0; i < ex; i++) begin
      w = 16'((b * 16'h0707) + (i * 16'h2D2D) + 16'h1357);
      crc = crc_ref(crc, w);
      send_edge(w, 1'b1);
    end
    n = 0;
    while (!stop_o && n < 40) begin @(negedge clk); n++; end
    chk(stop_o, "R4", "STOP raised", stop_o, 1);
    chk(!host_rdy, "R2", "ready stays low under STOP", host_rdy, 0);
    send_edge(16'hDEAD ^ 16'(b), 1'b0);
    repeat (2) @(negedge clk);
    chk(burst_words == CW'(nw + ex), "R5", "count after non-data edge", burst_words, nw + ex);
    chk(!bus_drive_en, "R6", "no drive while request high", bus_drive_en, 0);
    @(negedge clk) dev_req = 1'b0;
    n = 0;
    do begin @(posedge clk); @(negedge clk); n++; end while (!bus_drive_en && n < 40);
    chk(n == T_ZAH + 3, "R6", "edges request-low to drive", n, T_ZAH + 3);
    chk(bus_out == crc, "R7", "CRC word on bus", bus_out, crc);
    chk(done_o, "R8", "done with drive", done_o, 1);
    chk(burst_words == CW'(nw + ex), "R3", "final word count", burst_words, nw + ex);
    chk(stop_o, "R4", "STOP held in drive cycle", stop_o, 1);
    @(negedge clk);
    chk(!stop_o && !bus_drive_en && !done_o, "R4", "STOP/drive/done released",
        {stop_o, bus_drive_en, done_o}, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog: actual cycles=200000 expected fewer");
    report();
  end

  initial begin
    int b = 0;
    repeat (3) @(negedge clk);
    chk({host_rdy, stop_o, word_valid, bus_drive_en, done_o} == 5'b0, "R9",
        "outputs under reset", {host_rdy, stop_o, word_valid, bus_drive_en, done_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!host_rdy && !stop_o, "R9", "idle after reset", {host_rdy, stop_o}, 0);
    for (int nw = 1; nw <= 5; nw++)
      for (int ex = 0; ex <= 2; ex++) begin
        run_burst(b, nw, ex, 1'b0);
        b++;
      end
    for (int ex = 0; ex <= 2; ex++) begin
      run_burst(b, 1, ex, 1'b1);
      b++;
    end
    repeat (4) @(negedge clk);
    chk(mon_idx == exp_n, "R3", "total beats seen", mon_idx, exp_n);
    report();
  end
endmodule